// File: doc/BRIEF.md
# Port-Selected Collision Indicator

This block owns a single collision pin of a 10 Mb/s media access controller and decides, from a two-bit port selection, where the collision indication comes from. With the attachment-unit port chosen, it follows the collision signal reported by an external transceiver. It ignores that signal for a fixed window after every transmission, so that the transceiver's heartbeat (SQE test) burst is never taken for a collision. With the twisted-pair or the direct interface chosen, the block detects collision itself by seeing transmit and receive activity at the same time. With the serial port chosen, the pin turns around and becomes an input that an external encoder/decoder drives.

The registered internal collision flag feeds the MAC. A one-cycle abort request is raised when collision starts while a receive frame is in progress. Sleep and a pin-enable flag take the pin off the line (output enable low). Sleep also silences the collision logic.

Top module: `col_pin_ctrl`

## Requirements
- R1: While `sleep` is 1, `col_pin_oe` is 0, and `col_int` is 0 from the next clock on, whatever the port selection and activity inputs are.
- R2: While `pin_en` is 0 on port selections 00, 01 and 10, `col_pin_oe` is 0, but `col_int` is still produced from that port's sources.
- R3: `col_pin_oe` is 1 exactly when `sleep` is 0, `pin_en` is 1 and `port_sel` is 00, 01 or 10. It is a combinational function of these three inputs.
- R4: With `port_sel` = 00 (attachment port) and no mask window open, `col_int` one clock later equals `xcvr_col`. The twisted-pair and direct-interface inputs have no effect.
- R5: On port 00, a `tx_done` strobe sampled high masks `xcvr_col` at that clock edge and at the following `SQE_CLKS` edges (64 by default). `col_int` is 0 throughout, and collision is seen again on the next edge after that. The mask has no effect on the other port selections.
- R6: With `port_sel` = 01 (twisted pair), `col_int` one clock later is `tp_tx_act AND tp_rx_act`.
- R7: With `port_sel` = 10 (direct interface), `col_int` one clock later is `dir_crs AND dir_txen`.
- R8: With `port_sel` = 11 (serial port), the pin is an input. `col_int` one clock later equals `col_pin_in` when `pin_en` is 1, and is 0 when `pin_en` is 0.
- R9: `abort_req` is a one-cycle pulse, raised in the same cycle that `col_int` rises, if `rx_frame` was 1 at that clock edge. It is never raised without a rising collision.
- R10: While `rst` is 1 at a clock edge, `col_int`, `col_pin_out` and `abort_req` are 0 after that edge, and any open mask window is closed.
- R11: A `tx_done` strobe during an open mask window restarts the window at its full length.
- R12: `col_pin_out` always carries the same value as `col_int`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 2 | 00 attachment, 01 twisted pair, 10 direct interface, 11 serial |
| sleep | input | 1 | Sleep: pin released and collision logic silenced |
| pin_en | input | 1 | Pin enable flag |
| xcvr_col | input | 1 | Collision reported by the external transceiver pair |
| tp_tx_act | input | 1 | Twisted-pair transmit activity |
| tp_rx_act | input | 1 | Twisted-pair receive activity |
| dir_crs | input | 1 | Direct interface carrier sense |
| dir_txen | input | 1 | Direct interface transmit enable |
| tx_done | input | 1 | End-of-transmit strobe, opens the mask window |
| rx_frame | input | 1 | A receive frame is in progress |
| col_pin_in | input | 1 | Value seen on the pin when it acts as an input |
| col_pin_out | output | 1 | Value driven on the pin |
| col_pin_oe | output | 1 | Output enable of the pin |
| col_int | output | 1 | Registered internal collision flag |
| abort_req | output | 1 | One-cycle receive abort request |

## Verification
The abort pulse and the end of the mask window can fall on the same clock edge. A transceiver collision that is held high across a whole window, while a receive frame is in progress, rises inside the block exactly on the first unmasked edge. The bench holds `xcvr_col` and `rx_frame` high, strobes `tx_done`, and checks that `col_int` and `abort_req` stay low through the last masked edge. It then checks that both rise together on the next edge, and that the abort pulse is gone one edge later while collision stays high.

// File: rtl/colpin_pkg.sv
package colpin_pkg;

    typedef enum logic [1:0] {
        SEL_ATTACH  = 2'b00,
        SEL_TWISTED = 2'b01,
        SEL_DIRECT  = 2'b10,
        SEL_SERIAL  = 2'b11
    } port_sel_e;

    typedef struct packed {
        logic xcvr_col;
        logic tp_tx;
        logic tp_rx;
        logic dir_crs;
        logic dir_txen;
        logic pin_in;
    } col_src_t;

    // Pin is driven only for output-type ports while awake and enabled.
    function automatic logic pin_drives(port_sel_e sel, logic sleep_i, logic en_i);
        return !sleep_i && en_i && (sel != SEL_SERIAL);
    endfunction

endpackage

// File: rtl/sqe_mask_timer.sv
module sqe_mask_timer #(
    parameter int SQE_CLKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_done,
    output logic mask_on
);
    localparam int CW = $clog2(SQE_CLKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(SQE_CLKS);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (tx_done) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign mask_on = tx_done || (remain != '0);
endmodule

// File: rtl/col_source_sel.sv
module col_source_sel
    import colpin_pkg::*;
(
    input  port_sel_e sel,
    input  logic      sleep,
    input  logic      pin_en,
    input  col_src_t  src,
    input  logic      mask_on,
    output logic      col_raw
);
    logic picked;

    always_comb begin
        unique case (sel)
            SEL_ATTACH:  picked = src.xcvr_col && !mask_on;
            SEL_TWISTED: picked = src.tp_tx && src.tp_rx;
            SEL_DIRECT:  picked = src.dir_crs && src.dir_txen;
            SEL_SERIAL:  picked = src.pin_in && pin_en;
            default:     picked = 1'b0;
        endcase
        col_raw = picked && !sleep;
    end
endmodule

// File: rtl/col_edge_abort.sv
module col_edge_abort (
    input  logic clk,
    input  logic rst,
    input  logic col_raw,
    input  logic rx_frame,
    output logic col_q,
    output logic abort_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            col_q   <= col_raw;
            abort_q <= col_raw && !col_q && rx_frame;
        end
    end
endmodule

// File: rtl/col_pin_ctrl.sv
module col_pin_ctrl
    import colpin_pkg::*;
#(
    parameter int SQE_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] port_sel,
    input  logic       sleep,
    input  logic       pin_en,
    input  logic       xcvr_col,
    input  logic       tp_tx_act,
    input  logic       tp_rx_act,
    input  logic       dir_crs,
    input  logic       dir_txen,
    input  logic       tx_done,
    input  logic       rx_frame,
    input  logic       col_pin_in,
    output logic       col_pin_out,
    output logic       col_pin_oe,
    output logic       col_int,
    output logic       abort_req
);
    port_sel_e sel;
    col_src_t  src;
    logic      mask_on;
    logic      col_raw;

    assign sel = port_sel_e'(port_sel);
    assign src = '{xcvr_col: xcvr_col, tp_tx: tp_tx_act, tp_rx: tp_rx_act,
                   dir_crs: dir_crs, dir_txen: dir_txen, pin_in: col_pin_in};

    sqe_mask_timer #(.SQE_CLKS(SQE_CLKS)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .tx_done (tx_done),
        .mask_on (mask_on)
    );

    col_source_sel u_sel (
        .sel     (sel),
        .sleep   (sleep),
        .pin_en  (pin_en),
        .src     (src),
        .mask_on (mask_on),
        .col_raw (col_raw)
    );

    col_edge_abort u_edge (
        .clk      (clk),
        .rst      (rst),
        .col_raw  (col_raw),
        .rx_frame (rx_frame),
        .col_q    (col_int),
        .abort_q  (abort_req)
    );

    assign col_pin_out = col_int;
    assign col_pin_oe  = pin_drives(sel, sleep, pin_en);
endmodule

// File: rtl/col_pin_ctrl_chk.sv
module col_pin_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] port_sel,
    input logic       sleep,
    input logic       pin_en,
    input logic       tp_tx_act,
    input logic       tp_rx_act,
    input logic       dir_crs,
    input logic       dir_txen,
    input logic       tx_done,
    input logic       rx_frame,
    input logic       col_pin_in,
    input logic       col_pin_oe,
    input logic       col_int,
    input logic       abort_req
);
    p_sleep_pin_off_r1: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !col_pin_oe);

    p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !col_int);

    p_serial_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (port_sel == 2'b11) |-> !col_pin_oe);

    p_mask_on_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_done && port_sel == 2'b00) |=> !col_int);

    p_twisted_both_r6: assert property (@(posedge clk) disable iff (rst)
        (port_sel == 2'b01 && !sleep && tp_tx_act && tp_rx_act) |=> col_int);

    p_direct_both_r7: assert property (@(posedge clk) disable iff (rst)
        (port_sel == 2'b10 && !sleep && dir_crs && dir_txen) |=> col_int);

    p_serial_in_r8: assert property (@(posedge clk) disable iff (rst)
        (port_sel == 2'b11 && !sleep && pin_en && col_pin_in) |=> col_int);

    p_abort_single_r9: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> !abort_req);

    p_abort_with_col_r9: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> (col_int && $past(rx_frame)));
endmodule

bind col_pin_ctrl col_pin_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_sel   (port_sel),
    .sleep      (sleep),
    .pin_en     (pin_en),
    .tp_tx_act  (tp_tx_act),
    .tp_rx_act  (tp_rx_act),
    .dir_crs    (dir_crs),
    .dir_txen   (dir_txen),
    .tx_done    (tx_done),
    .rx_frame   (rx_frame),
    .col_pin_in (col_pin_in),
    .col_pin_oe (col_pin_oe),
    .col_int    (col_int),
    .abort_req  (abort_req)
);

// File: tb/col_pin_ctrl_tb.sv
module col_pin_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SQE        = 64;
    localparam int NVEC       = 14;

    // {sel[1:0], sleep, pin_en, xcvr, tp_tx, tp_rx, crs, txen, pin_in, exp_out, exp_oe}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b00_0_1_1_0_0_0_0_0_1_1,
        12'b00_0_1_0_1_1_1_1_1_0_1,
        12'b01_0_1_0_1_1_0_0_0_1_1,
        12'b01_0_1_1_1_0_1_1_1_0_1,
        12'b01_0_1_0_0_1_0_0_0_0_1,
        12'b10_0_1_0_0_0_1_1_0_1_1,
        12'b10_0_1_1_1_1_1_0_1_0_1,
        12'b11_0_1_0_0_0_0_0_1_1_0,
        12'b11_0_1_1_1_1_1_1_0_0_0,
        12'b11_0_0_0_0_0_0_0_1_0_0,
        12'b00_0_0_1_0_0_0_0_0_1_0,
        12'b00_1_1_1_0_0_0_0_0_0_0,
        12'b01_1_1_0_1_1_0_0_0_0_0,
        12'b11_1_1_0_0_0_0_0_1_0_0
    };

    logic clk = 1'b0;
    logic rst;
    logic [1:0] port_sel;
    logic sleep, pin_en, xcvr_col, tp_tx_act, tp_rx_act, dir_crs, dir_txen;
    logic tx_done, rx_frame, col_pin_in;
    logic col_pin_out, col_pin_oe, col_int, abort_req;

    int n_total = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    col_pin_ctrl #(.SQE_CLKS(SQE)) u_dut (
        .clk(clk), .rst(rst), .port_sel(port_sel), .sleep(sleep), .pin_en(pin_en),
        .xcvr_col(xcvr_col), .tp_tx_act(tp_tx_act), .tp_rx_act(tp_rx_act),
        .dir_crs(dir_crs), .dir_txen(dir_txen), .tx_done(tx_done),
        .rx_frame(rx_frame), .col_pin_in(col_pin_in), .col_pin_out(col_pin_out),
        .col_pin_oe(col_pin_oe), .col_int(col_int), .abort_req(abort_req)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic idle();
        port_sel = 2'b00; sleep = 1'b0; pin_en = 1'b1; xcvr_col = 1'b0;
        tp_tx_act = 1'b0; tp_rx_act = 1'b0; dir_crs = 1'b0; dir_txen = 1'b0;
        tx_done = 1'b0; rx_frame = 1'b0; col_pin_in = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string row_tag(input logic [11:0] v);
        if (v[9]) return "R1";
        if (!v[8] && v[11:10] != 2'b11) return "R2";
        case (v[11:10])
            2'b00:   return "R4";
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        idle();
        xcvr_col = 1'b1;
        rst = 1'b1;
        step(3);
        // R10: reset clears the registered outputs
        check("R10", "col_pin_out in reset", col_pin_out, 1'b0);
        check("R10", "col_int in reset", col_int, 1'b0);
        check("R10", "abort_req in reset", abort_req, 1'b0);
        xcvr_col = 1'b0;
        rst = 1'b0;
        step(2);

        // Table walk: one vector per clock
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            port_sel = v[11:10]; sleep = v[9]; pin_en = v[8]; xcvr_col = v[7];
            tp_tx_act = v[6]; tp_rx_act = v[5]; dir_crs = v[4]; dir_txen = v[3];
            col_pin_in = v[2];
            #1;
            check(v[9] ? "R1" : "R3", "col_pin_oe", col_pin_oe, v[0]);
            step(1);
            check(row_tag(v), "col_int", col_int, v[1]);
            check("R12", "col_pin_out", col_pin_out, v[1]);
        end

        // R5: mask window on the attachment port
        idle();
        xcvr_col = 1'b1;
        step(3);
        check("R4", "collision before strobe", col_int, 1'b1);
        tx_done = 1'b1;
        step(1);
        tx_done = 1'b0;
        check("R5", "masked at strobe edge", col_int, 1'b0);
        step(SQE);
        check("R5", "masked at last window edge", col_int, 1'b0);
        step(1);
        check("R5", "seen after window", col_int, 1'b1);

        // R11: retrigger restarts the window
        tx_done = 1'b1;
        step(1);
        tx_done = 1'b0;
        step(29);
        tx_done = 1'b1;
        step(1);
        tx_done = 1'b0;
        step(SQE);
        check("R11", "masked after retrigger", col_int, 1'b0);
        step(1);
        check("R11", "seen after retriggered window", col_int, 1'b1);

        // R5: mask has no effect on the twisted-pair port
        idle();
        port_sel = 2'b01; tp_tx_act = 1'b1; tp_rx_act = 1'b1;
        tx_done = 1'b1;
        step(1);
        tx_done = 1'b0;
        check("R5", "twisted pair ignores mask", col_int, 1'b1);

        // R9: abort pulse on rising collision with receive in progress
        idle();
        port_sel = 2'b01; rx_frame = 1'b1;
        step(2);
        tp_tx_act = 1'b1; tp_rx_act = 1'b1;
        step(1);
        check("R9", "abort on rise", abort_req, 1'b1);
        check("R9", "collision on rise", col_int, 1'b1);
        step(1);
        check("R9", "abort single cycle", abort_req, 1'b0);
        check("R9", "collision held", col_int, 1'b1);

        // R9: no abort without receive in progress
        idle();
        port_sel = 2'b10;
        step(2);
        dir_crs = 1'b1; dir_txen = 1'b1;
        step(1);
        check("R9", "no abort without rx_frame", abort_req, 1'b0);
        check("R7", "direct collision", col_int, 1'b1);

        // R8 with R9: serial input collision aborts reception
        idle();
        port_sel = 2'b11; rx_frame = 1'b1;
        step(2);
        col_pin_in = 1'b1;
        step(1);
        check("R8", "serial input collision", col_int, 1'b1);
        check("R9", "serial abort", abort_req, 1'b1);

        // Mask release coincides with rising collision and abort
        idle();
        step(2);
        xcvr_col = 1'b1; rx_frame = 1'b1; tx_done = 1'b1;
        step(1);
        tx_done = 1'b0;
        step(SQE);
        check("R5", "held off at window end", col_int, 1'b0);
        check("R9", "no abort inside window", abort_req, 1'b0);
        step(1);
        check("R5", "rise at window release", col_int, 1'b1);
        check("R9", "abort at window release", abort_req, 1'b1);
        step(1);
        check("R9", "abort gone after release", abort_req, 1'b0);

        // R1: sleep silences a running collision
        sleep = 1'b1;
        step(1);
        check("R1", "sleep clears collision", col_int, 1'b0);
        check("R1", "sleep releases pin", col_pin_oe, 1'b0);

        // R10: reset closes an open window
        idle();
        xcvr_col = 1'b1; tx_done = 1'b1;
        step(1);
        tx_done = 1'b0; rst = 1'b1;
        step(1);
        rst = 1'b0;
        step(1);
        check("R10", "reset closed window", col_int, 1'b1);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule